// File: doc/BRIEF.md
# Busy-Release Detector with Timeout

This block decides when a controller may begin reading from an external device that signals activity on an active-high busy line. The busy line is not related to the system clock. It first passes through a chain of flip-flops that guards against metastability. The block then compares two registered samples of the synchronized level to find the moment busy is released, which is a change from 1 to 0.

A controller arms the block with a one-cycle start request. While armed, the block waits for a release and counts clock cycles. If a release is seen, the block emits a one-cycle read-start pulse. If no release arrives within a fixed number of cycles, the same pulse is emitted and a flag marks it as caused by the timeout. After the pulse the block goes back to idle and does nothing until it is armed again.

There is no data stream in or out of the block, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure.

Top module: `busy_release_watch`

## Requirements
- R1: The busy input passes through SYNC_STAGES flip-flops (at least 2, default 2) before any logic uses it. With the default depth, a release while armed produces read_start on the third rising clock edge after busy falls, whatever the phase of the fall.
- R2: A release is a synchronized sample of 1 followed by a sample of 0 on the next cycle. A rise of busy, or a level that does not change, never produces read_start.
- R3: In idle, a high start at a rising edge arms the block and clears its cycle counter. A start while already armed is ignored and does not restart the count.
- R4: If no release occurs while armed, read_start and timed_out are both 1 for the cycle after the TIMEOUT-th rising edge that follows the edge which sampled start. TIMEOUT defaults to 1500.
- R5: read_start is high for exactly one cycle, and the block is idle in the cycle that follows it.
- R6: A release that happens while idle, including just after a pulse, produces no read_start.
- R7: If a release and the timeout fall in the same cycle, the release wins and timed_out is 0.
- R8: timed_out is 1 only together with read_start, and only when the counter alone caused the pulse.
- R9: Synchronous active-high reset sets every synchronizer flop and the previous-sample flop to 1, and leaves the block idle with both outputs low. Reset therefore creates no false release.
- R10: If busy is already low when the block is armed, no release is seen, and the pulse comes from the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| busy_async | input | 1 | Busy line from the external device, asynchronous |
| start | input | 1 | Arm request, one cycle |
| read_start | output | 1 | One-cycle permission to begin reading |
| timed_out | output | 1 | High with read_start when the timeout caused it |

## Verification
The bound checker watches these properties on every cycle:
- read_start stays one cycle wide and never appears unless the block was armed.
- timed_out never appears without read_start.
- A detected release always follows a synchronized 1 then 0.
- A timeout pulse arrives exactly TIMEOUT cycles after arming. An independent counter in the checker measures this.

Some behaviours can only be shown by the bench's scenarios:
- The fixed three-edge latency from an unsynchronized fall, measured at every phase inside the clock period.
- The priority between a release and the timeout in the same cycle, and the case one cycle later.
- That releases are ignored while idle.
- That a second start does not restart the count.
- That arming with busy already low falls back to the timeout.

// File: rtl/busy_release_pkg.sv
package busy_release_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } watch_state_t;
endpackage

// File: rtl/busy_sync.sv
module busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/fall_detect.sv
module fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic fell
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b1;
    else     level_q <= level;
  end

  assign fell = level_q & ~level;
endmodule

// File: rtl/release_fsm.sv
module release_fsm
  import busy_release_pkg::*;
#(
  parameter int TIMEOUT = 1500,
  parameter int CNT_W   = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic fell,
  output logic read_start,
  output logic timed_out,
  output logic armed
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  watch_state_t state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      read_start <= 1'b0;
      timed_out  <= 1'b0;
    end else begin
      read_start <= 1'b0;
      timed_out  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_WAIT;
            cnt   <= '0;
          end
        end
        ST_WAIT: begin
          if (fell) begin
            read_start <= 1'b1;
            state      <= ST_IDLE;
          end else if (cnt == LAST) begin
            read_start <= 1'b1;
            timed_out  <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign armed = (state == ST_WAIT);
endmodule

// File: rtl/busy_release_watch.sv
module busy_release_watch #(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT     = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic busy_async,
  input  logic start,
  output logic read_start,
  output logic timed_out
);
  localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  logic sync_busy;
  logic fall;
  logic armed;

  busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (busy_async),
    .dout (sync_busy)
  );

  fall_detect u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (sync_busy),
    .fell  (fall)
  );

  release_fsm #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .fell       (fall),
    .read_start (read_start),
    .timed_out  (timed_out),
    .armed      (armed)
  );
endmodule

// File: rtl/busy_release_checker.sv
module busy_release_checker #(
  parameter int TIMEOUT = 1500
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic read_start,
  input logic timed_out,
  input logic sync_busy,
  input logic fall,
  input logic armed
);
  localparam int CK_W = $clog2(TIMEOUT + 2) + 1;
  logic [CK_W-1:0] since_arm;

  always_ff @(posedge clk) begin
    if (rst)         since_arm <= '0;
    else if (!armed) since_arm <= start ? CK_W'(1) : '0;
    else             since_arm <= since_arm + 1'b1;
  end

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    read_start |=> (!read_start && !armed));

  assert_only_when_armed_R6: assert property (@(posedge clk) disable iff (rst)
    read_start |-> $past(armed));

  assert_flag_with_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    timed_out |-> read_start);

  assert_fall_shape_R2: assert property (@(posedge clk) disable iff (rst)
    fall |-> ($past(sync_busy) && !sync_busy));

  assert_timeout_exact_R4: assert property (@(posedge clk) disable iff (rst)
    timed_out |-> (since_arm == CK_W'(TIMEOUT + 1)));

  assert_no_overrun_R3: assert property (@(posedge clk) disable iff (rst)
    armed |-> (since_arm <= CK_W'(TIMEOUT)));

  assert_no_reset_edge_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!fall && !read_start));
endmodule

bind busy_release_watch busy_release_checker #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .read_start (read_start),
  .timed_out  (timed_out),
  .sync_busy  (sync_busy),
  .fall       (fall),
  .armed      (armed)
);

// File: tb/sim_busy_release_watch.sv
`timescale 1ns/1ps
module sim_busy_release_watch;
  localparam int TMO = 1500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy_async = 1'b1;
  logic start = 1'b0;
  logic read_start, timed_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  busy_release_watch #(.SYNC_STAGES(2), .TIMEOUT(TMO)) u0 (
    .clk        (clk),
    .rst        (rst),
    .busy_async (busy_async),
    .start      (start),
    .read_start (read_start),
    .timed_out  (timed_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_pulse(input int maxk, output int k, output logic flag);
    k = -1; flag = 1'b0;
    for (int i = 1; i <= maxk; i++) begin
      @(posedge clk); @(negedge clk);
      if (read_start) begin k = i; flag = timed_out; break; end
    end
  endtask

  task automatic settle_high();
    @(negedge clk); busy_async = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int k;
    logic fl;
    int seen;

    // R9: reset state, then arm at once; no early pulse
    repeat (4) @(negedge clk);
    check("R9 read_start in reset", read_start, 0);
    check("R9 timed_out in reset", timed_out, 0);
    rst = 1'b0;
    arm();
    wait_pulse(TMO + 10, k, fl);
    check("R9/R4 first pulse after reset at timeout", k, TMO);
    check("R4 timed_out flag", fl, 1);
    @(posedge clk); @(negedge clk);
    check("R5 pulse single cycle", read_start, 0);

    // R1/R2: sweep release phase and wait before release
    for (int d = 0; d < 4; d++) begin
      for (int p = 1; p < 20; p++) begin
        settle_high();
        arm();
        repeat (d * 3) @(negedge clk);
        @(posedge clk); #(p);
        busy_async = 1'b0;
        wait_pulse(10, k, fl);
        check($sformatf("R1 latency d=%0d p=%0d", d, p), k, 3);
        check($sformatf("R8 edge flag d=%0d p=%0d", d, p), fl, 0);
      end
    end

    // R6: releases while idle are ignored
    settle_high();
    busy_async = 1'b0;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); @(negedge clk);
      if (read_start) seen++;
    end
    check("R6 idle release ignored", seen, 0);

    // R10: armed with busy already low -> timeout
    arm();
    wait_pulse(TMO + 10, k, fl);
    check("R10 low-at-arm pulse time", k, TMO);
    check("R10 low-at-arm flag", fl, 1);

    // R2: rise while armed does not fire; timeout follows
    arm();
    repeat (5) @(negedge clk);
    busy_async = 1'b1;
    wait_pulse(TMO + 10, k, fl);
    check("R2 rise no pulse, timeout time", k, TMO - 5);
    check("R2 rise flag", fl, 1);

    // R3: second start while armed is ignored
    settle_high();
    arm();
    repeat (699) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_pulse(TMO + 10, k, fl);
    check("R3 restart ignored, timeout time", k, TMO - 700);
    check("R3 flag", fl, 1);

    // R7: release and timeout in the same cycle
    settle_high();
    arm();
    for (int i = 0; i < TMO - 3; i++) @(posedge clk);
    #5 busy_async = 1'b0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (read_start) begin seen++; check("R7 same-cycle flag is edge", timed_out, 0); end
      @(posedge clk);
    end
    check("R7 one pulse", seen, 1);

    // R4/R7: release one cycle too late -> timeout wins
    settle_high();
    arm();
    for (int i = 0; i < TMO - 2; i++) @(posedge clk);
    #5 busy_async = 1'b0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (read_start) begin seen++; check("R4 late release flag", timed_out, 1); end
      @(posedge clk);
    end
    check("R4 late release one pulse", seen, 1);

    // R6/R5: after a pulse, a new release does nothing
    settle_high();
    arm();
    @(posedge clk); #3 busy_async = 1'b0;
    wait_pulse(10, k, fl);
    check("R5 pulse before re-release", k, 3);
    @(negedge clk); busy_async = 1'b1;
    repeat (4) @(negedge clk);
    busy_async = 1'b0;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); @(negedge clk);
      if (read_start) seen++;
    end
    check("R6 release after pulse ignored", seen, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule